// File: doc/BRIEF.md
# Vector Floating-Point Compare with Condition Code

This block compares two 128-bit vectors that each hold four binary32 lanes. Each lane pair is compared with one of three predicates: equal, greater-than, or greater-or-equal. A lane that satisfies the predicate produces an all-ones mask word. Any other lane produces a zero word. A 2-bit condition code then summarises the lane results as all, some or none matching. The block also reports a per-lane invalid-operation flag. Whether quiet NaNs raise that flag depends on the quiet or signaling comparison mode.

A single-element mode limits the work to lane 0. In that mode the condition code reflects only lane 0. A request is accepted when `cmp_go` is high. The results appear on registered outputs one clock later and then hold until the next request.

Top module: `vfcmp_cc_unit`

## Requirements
- R1: Lane i occupies bits [32*i+31:32*i] of each vector, with lane 0 in the low bits. Every mask lane is either 32'hFFFF_FFFF (match) or 32'h0 (no match or not processed).
- R2: Predicate code 0 (equal) matches when the two lanes are numerically equal. +0 and -0 count as equal.
- R3: Predicate code 1 matches when src_a > src_b, which is evaluated as src_b < src_a. Code 2 matches when src_a >= src_b. Code 3 never matches.
- R4: When either operand of a lane is a NaN (exponent all ones, fraction nonzero), that lane does not match, whatever the predicate.
- R5: When single_elem is 1, only lane 0 is compared. Lanes 1 to 3 give a zero mask and a zero invalid flag.
- R6: With single_elem at 0, cc_code is 0 when all four lanes match, 1 when some but not all match, and 3 when none match. It is never 2.
- R7: With single_elem at 1, cc_code is 0 when lane 0 matches and 3 otherwise.
- R8: In quiet mode (signal_cmp = 0), a lane's invalid bit is set only when an operand is a signaling NaN. A signaling NaN has fraction bit 22 clear and a nonzero fraction.
- R9: In signaling mode (signal_cmp = 1), a lane's invalid bit is set when either operand is any NaN.
- R10: Results are registered one cycle after a cycle with cmp_go high. res_valid is high for exactly that cycle. Outputs hold their values while cmp_go is low.
- R11: During reset, res_valid, lane_mask, cc_code and invalid_flag are all zero.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| cmp_go | input | 1 | Accept the operands this cycle |
| src_a | input | 128 | First operand vector, four binary32 lanes |
| src_b | input | 128 | Second operand vector |
| pred_sel | input | 2 | 0 equal, 1 greater-than, 2 greater-or-equal, 3 none |
| signal_cmp | input | 1 | 1 selects signaling mode, 0 selects quiet mode |
| single_elem | input | 1 | Compare lane 0 only |
| res_valid | output | 1 | Results updated in this cycle |
| lane_mask | output | 128 | Per-lane all-ones / all-zeros result |
| cc_code | output | 2 | Condition code: 0 all, 1 some, 3 none |
| invalid_flag | output | 4 | Per-lane invalid-operation flag |

## Verification
Every result register is loaded from one request and is visible in the very next cycle. A wrong lane decision therefore shows up at once on the same lane's mask word and, in most cases, on cc_code too. A lane-gating fault in single-element mode appears as nonzero upper mask words or invalid bits in the first result after such a request. A fault in the hold enable shows as mask or code changes during idle cycles, which the bench probes by changing the operands while cmp_go is low.

// File: rtl/vfcmp_pkg.sv
package vfcmp_pkg;
  localparam int unsigned EXP_W  = 8;
  localparam int unsigned FRAC_W = 23;
  localparam int unsigned FP_W   = 1 + EXP_W + FRAC_W;

  typedef enum logic [1:0] {
    PRED_EQ   = 2'd0,
    PRED_GT   = 2'd1,
    PRED_GE   = 2'd2,
    PRED_NONE = 2'd3
  } pred_e;

  localparam logic [1:0] CC_ALL  = 2'd0;
  localparam logic [1:0] CC_SOME = 2'd1;
  localparam logic [1:0] CC_NONE = 2'd3;
endpackage

// File: rtl/vfcmp_lane.sv
module vfcmp_lane
  import vfcmp_pkg::*;
(
  input  logic [FP_W-1:0] a_in,
  input  logic [FP_W-1:0] b_in,
  input  pred_e           pred,
  input  logic            sig_mode,
  input  logic            lane_en,
  output logic            hit,
  output logic            inv
);
  logic a_nan, b_nan, a_snan, b_snan, any_nan, both_zero;
  logic a_s, b_s;
  logic [FP_W-2:0] a_mag, b_mag;
  logic is_eq, b_lt_a, raw_hit;

  always_comb begin
    a_s    = a_in[FP_W-1];
    b_s    = b_in[FP_W-1];
    a_mag  = a_in[FP_W-2:0];
    b_mag  = b_in[FP_W-2:0];
    a_nan  = (&a_in[FP_W-2:FRAC_W]) && (a_in[FRAC_W-1:0] != '0);
    b_nan  = (&b_in[FP_W-2:FRAC_W]) && (b_in[FRAC_W-1:0] != '0);
    a_snan = a_nan && !a_in[FRAC_W-1];
    b_snan = b_nan && !b_in[FRAC_W-1];
    any_nan   = a_nan || b_nan;
    both_zero = (a_mag == '0) && (b_mag == '0);
    is_eq  = !any_nan && ((a_in == b_in) || both_zero);
    // second operand strictly below first
    b_lt_a = !any_nan && !both_zero &&
             ((b_s && !a_s) ||
              (!b_s && !a_s && (b_mag < a_mag)) ||
              (b_s && a_s && (b_mag > a_mag)));
    unique case (pred)
      PRED_EQ: raw_hit = is_eq;
      PRED_GT: raw_hit = b_lt_a;
      PRED_GE: raw_hit = b_lt_a || is_eq;
      default: raw_hit = 1'b0;
    endcase
    hit = lane_en && raw_hit;
    inv = lane_en && (sig_mode ? any_nan : (a_snan || b_snan));
  end
endmodule

// File: rtl/vfcmp_ccgen.sv
module vfcmp_ccgen
  import vfcmp_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic [LANES-1:0] hits,
  input  logic             single,
  output logic [1:0]       cc
);
  always_comb begin
    if (single)        cc = hits[0] ? CC_ALL : CC_NONE;
    else if (&hits)    cc = CC_ALL;
    else if (|hits)    cc = CC_SOME;
    else               cc = CC_NONE;
  end
endmodule

// File: rtl/vfcmp_cc_unit.sv
module vfcmp_cc_unit
  import vfcmp_pkg::*;
#(
  parameter int unsigned LANES = 4
) (
  input  logic                  clk,
  input  logic                  rst_n,
  input  logic                  cmp_go,
  input  logic [LANES*FP_W-1:0] src_a,
  input  logic [LANES*FP_W-1:0] src_b,
  input  logic [1:0]            pred_sel,
  input  logic                  signal_cmp,
  input  logic                  single_elem,
  output logic                  res_valid,
  output logic [LANES*FP_W-1:0] lane_mask,
  output logic [1:0]            cc_code,
  output logic [LANES-1:0]      invalid_flag
);
  localparam int unsigned VW = LANES * FP_W;

  pred_e             pred;
  logic [LANES-1:0]  hit_c, inv_c;
  logic [VW-1:0]     mask_c, mask_q;
  logic [1:0]        cc_c, cc_q;
  logic [LANES-1:0]  inv_q;
  logic              vld_q;

  assign pred = pred_e'(pred_sel);

  for (genvar i = 0; i < LANES; i++) begin : g_lane
    logic en;
    assign en = !single_elem || (i == 0);
    vfcmp_lane u_lane (
      .a_in    (src_a[i*FP_W +: FP_W]),
      .b_in    (src_b[i*FP_W +: FP_W]),
      .pred    (pred),
      .sig_mode(signal_cmp),
      .lane_en (en),
      .hit     (hit_c[i]),
      .inv     (inv_c[i])
    );
    assign mask_c[i*FP_W +: FP_W] = {FP_W{hit_c[i]}};
  end

  vfcmp_ccgen #(.LANES(LANES)) u_cc (
    .hits  (hit_c),
    .single(single_elem),
    .cc    (cc_c)
  );

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) vld_q <= 1'b0;
    else        vld_q <= cmp_go;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      mask_q <= '0;
      cc_q   <= '0;
      inv_q  <= '0;
    end else if (cmp_go) begin
      mask_q <= mask_c;
      cc_q   <= cc_c;
      inv_q  <= inv_c;
    end
  end

  assign res_valid    = vld_q;
  assign lane_mask    = mask_q;
  assign cc_code      = cc_q;
  assign invalid_flag = inv_q;
endmodule

// File: rtl/vfcmp_cc_unit_chk.sv
module vfcmp_cc_unit_chk #(
  parameter int unsigned LANES = 4,
  parameter int unsigned FPW   = 32
) (
  input logic                 clk,
  input logic                 rst_n,
  input logic                 cmp_go,
  input logic                 single_elem,
  input logic                 res_valid,
  input logic [LANES*FPW-1:0] lane_mask,
  input logic [1:0]           cc_code,
  input logic [LANES-1:0]     invalid_flag
);
  for (genvar i = 0; i < LANES; i++) begin : g_chk
    a_r1_lane_uniform: assert property (@(posedge clk) disable iff (!rst_n)
      (lane_mask[i*FPW +: FPW] == '0) || (&lane_mask[i*FPW +: FPW]));
  end

  a_r5_single_upper_clear: assert property (@(posedge clk) disable iff (!rst_n)
    $past(cmp_go && single_elem) |->
      (lane_mask[LANES*FPW-1:FPW] == '0) && (invalid_flag[LANES-1:1] == '0));

  a_r6_cc_never_two: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid |-> cc_code != 2'd2);

  a_r6_all_hit_cc0: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (&lane_mask)) |-> cc_code == 2'd0);

  a_r6_no_hit_cc3: assert property (@(posedge clk) disable iff (!rst_n)
    (res_valid && (lane_mask == '0)) |-> cc_code == 2'd3);

  a_r10_valid_follows_go: assert property (@(posedge clk) disable iff (!rst_n)
    res_valid == $past(cmp_go));

  a_r10_hold_idle: assert property (@(posedge clk) disable iff (!rst_n)
    !$past(cmp_go) |-> ($stable(lane_mask) && $stable(cc_code) && $stable(invalid_flag)));
endmodule

bind vfcmp_cc_unit vfcmp_cc_unit_chk #(.LANES(LANES), .FPW(vfcmp_pkg::FP_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .single_elem(single_elem),
  .res_valid(res_valid), .lane_mask(lane_mask), .cc_code(cc_code),
  .invalid_flag(invalid_flag)
);

// File: tb/vfcmp_cc_unit_tb.sv
module vfcmp_cc_unit_tb;
  logic         clk = 1'b0;
  logic         rst_n;
  logic         cmp_go;
  logic [127:0] src_a, src_b;
  logic [1:0]   pred_sel;
  logic         signal_cmp, single_elem;
  logic         res_valid;
  logic [127:0] lane_mask;
  logic [1:0]   cc_code;
  logic [3:0]   invalid_flag;

  int n_chk = 0;
  int n_bad = 0;

  always #2 clk = ~clk;

  vfcmp_cc_unit u_dut (
    .clk(clk), .rst_n(rst_n), .cmp_go(cmp_go), .src_a(src_a), .src_b(src_b),
    .pred_sel(pred_sel), .signal_cmp(signal_cmp), .single_elem(single_elem),
    .res_valid(res_valid), .lane_mask(lane_mask), .cc_code(cc_code),
    .invalid_flag(invalid_flag)
  );

  function automatic bit is_nan(logic [31:0] x);
    return (x[30:23] == 8'hFF) && (x[22:0] != 0);
  endfunction
  function automatic bit is_snan(logic [31:0] x);
    return is_nan(x) && !x[22];
  endfunction
  function automatic longint key(logic [31:0] x);
    longint m = longint'(x[30:0]);
    return x[31] ? -m : m;
  endfunction
  function automatic bit ref_hit(logic [31:0] a, logic [31:0] b, logic [1:0] p);
    if (is_nan(a) || is_nan(b)) return 1'b0;
    case (p)
      2'd0: return key(a) == key(b);
      2'd1: return key(a) > key(b);
      2'd2: return key(a) >= key(b);
      default: return 1'b0;
    endcase
  endfunction

  task automatic chk(string req, logic [127:0] act, logic [127:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic run(logic [127:0] a, logic [127:0] b, logic [1:0] p, logic sm, logic se);
    logic [127:0] em;
    logic [3:0]   eh, ei;
    logic [1:0]   ec;
    @(negedge clk);
    src_a = a; src_b = b; pred_sel = p; signal_cmp = sm; single_elem = se; cmp_go = 1'b1;
    for (int i = 0; i < 4; i++) begin
      logic [31:0] x = a[i*32 +: 32];
      logic [31:0] y = b[i*32 +: 32];
      bit act = !se || (i == 0);
      eh[i] = act && ref_hit(x, y, p);
      ei[i] = act && (sm ? (is_nan(x) || is_nan(y)) : (is_snan(x) || is_snan(y)));
      em[i*32 +: 32] = {32{eh[i]}};
    end
    if (se)          ec = eh[0] ? 2'd0 : 2'd3;
    else if (&eh)    ec = 2'd0;
    else if (|eh)    ec = 2'd1;
    else             ec = 2'd3;
    @(negedge clk);
    cmp_go = 1'b0;
    chk("R10 valid", {127'd0, res_valid}, 128'd1);
    chk("R1/R2/R3/R4/R5 mask", lane_mask, em);
    chk(se ? "R7 cc" : "R6 cc", {126'd0, cc_code}, {126'd0, ec});
    chk(sm ? "R9 invalid" : "R8 invalid", {124'd0, invalid_flag}, {124'd0, ei});
  endtask

  function automatic logic [31:0] pick();
    case ($urandom_range(0, 13))
      0: return 32'h0000_0000;
      1: return 32'h8000_0000;
      2: return 32'h3F80_0000;
      3: return 32'hBF80_0000;
      4: return 32'h4000_0000;
      5: return 32'h7F80_0000;
      6: return 32'hFF80_0000;
      7: return 32'h7FC0_0000;
      8: return 32'h7F80_0001;
      9: return 32'hFFA0_0000;
      10: return 32'h0000_0001;
      default: return $urandom();
    endcase
  endfunction

  logic done = 1'b0;

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      n_chk++; n_bad++;
      $display("FAIL watchdog expired");
      $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
      $finish;
    end
  end

  initial begin
    logic [127:0] ha, hm;
    logic [1:0]   hc;
    void'($urandom(32'd20240607));
    rst_n = 1'b0; cmp_go = 1'b0; src_a = '0; src_b = '0;
    pred_sel = 2'd0; signal_cmp = 1'b0; single_elem = 1'b0;
    repeat (3) @(negedge clk);
    // R11: reset state
    chk("R11 valid", {127'd0, res_valid}, 128'd0);
    chk("R11 mask", lane_mask, 128'd0);
    chk("R11 cc", {126'd0, cc_code}, 128'd0);
    chk("R11 invalid", {124'd0, invalid_flag}, 128'd0);
    rst_n = 1'b1;

    // R2: +0 vs -0 equal, all lanes -> cc 0
    run({32'h8000_0000, 32'h3F80_0000, 32'h0000_0000, 32'h4000_0000},
        {32'h0000_0000, 32'h3F80_0000, 32'h8000_0000, 32'h4000_0000}, 2'd0, 1'b0, 1'b0);
    // R3: greater-than with negatives, partial match -> cc 1
    run({32'hBF80_0000, 32'h4000_0000, 32'hC000_0000, 32'h3F80_0000},
        {32'hC000_0000, 32'h3F80_0000, 32'hBF80_0000, 32'h3F80_0000}, 2'd1, 1'b0, 1'b0);
    // R3: greater-or-equal, and code 3 never matches
    run({4{32'h3F80_0000}}, {4{32'h3F80_0000}}, 2'd2, 1'b0, 1'b0);
    run({4{32'h3F80_0000}}, {4{32'h3F80_0000}}, 2'd3, 1'b0, 1'b0);
    // R4/R8/R9: NaNs never match; quiet vs signaling invalid
    run({32'h7FC0_0000, 32'h7F80_0001, 32'h7FC0_0000, 32'h3F80_0000},
        {32'h7FC0_0000, 32'h3F80_0000, 32'h3F80_0000, 32'hFFA0_0000}, 2'd0, 1'b0, 1'b0);
    run({32'h7FC0_0000, 32'h7F80_0001, 32'h7FC0_0000, 32'h3F80_0000},
        {32'h7FC0_0000, 32'h3F80_0000, 32'h3F80_0000, 32'hFFA0_0000}, 2'd2, 1'b1, 1'b0);
    // R5/R7: single-element, upper lanes would match / carry NaNs
    run({32'h7F80_0001, 32'h7F80_0001, 32'h3F80_0000, 32'h0000_0000},
        {32'h7F80_0001, 32'h7F80_0001, 32'h3F80_0000, 32'h3F80_0000}, 2'd0, 1'b1, 1'b1);
    run({32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h4000_0000},
        {32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000, 32'h3F80_0000}, 2'd1, 1'b0, 1'b1);

    // R10: outputs hold while idle even as inputs change
    hm = lane_mask; hc = cc_code; ha = src_a;
    @(negedge clk);
    src_a = ~ha; src_b = '0; pred_sel = 2'd2; single_elem = 1'b0;
    @(negedge clk);
    chk("R10 idle valid", {127'd0, res_valid}, 128'd0);
    chk("R10 hold mask", lane_mask, hm);
    chk("R10 hold cc", {126'd0, cc_code}, {126'd0, hc});

    for (int n = 0; n < 400; n++) begin
      logic [127:0] ra, rb;
      for (int i = 0; i < 4; i++) begin
        ra[i*32 +: 32] = pick();
        rb[i*32 +: 32] = ($urandom_range(0, 3) == 0) ? ra[i*32 +: 32] : pick();
      end
      run(ra, rb, 2'($urandom_range(0, 3)), 1'($urandom_range(0, 1)),
          ($urandom_range(0, 4) == 0));
    end

    done = 1'b1;
    $display("%0d/%0d checks passed", n_chk - n_bad, n_chk);
    $finish;
  end
endmodule